// File: doc/BRIEF.md
# Banked Host Register Bank for an Acquisition Controller

This block is the byte-wide host-side register file of a data-acquisition controller. It occupies sixteen byte offsets. The offset used to configure the controller is shared by three write registers: a two-bit bank field picks which one a host write reaches. A second offset carries that bank field together with the input range code. Bit 7 of the byte written there decides which of the two fields the write is allowed to change. The conversion engine, timers and FIFO elsewhere in the controller read the decoded fields directly from dedicated output pins.

On the read side, three offsets return status and readback bytes. These bytes are assembled from the live status inputs and the stored fields. The upper status offset returns a second status byte, or an identification byte when the bank field is 11. A write lands on the rising clock edge when `wrEn` is high. Read data is combinational and is driven only while `rdEn` is high.

Top module: `acqHostRegs`

## Requirements
- R1: After reset, every stored field reads zero: the digital outputs are low, the bank field is 00, and the range code and all enables are 0.
- R2: A write to offset 2 with bank 00 loads the digital outputs from bits 7:4, the interrupt enable from bit 3 and the multiplexer address from bits 2:0.
- R3: A write to offset 2 with bank 01 loads the conversion fields as follows: bit 7 hardware-convert enable, bit 5 gate enable, bit 4 scan enable, bit 3 interrupt source (1 means end of conversion), bit 2 trigger enable, bit 1 cascade enable, bit 0 internal timebase enable. Bit 6 is discarded.
- R4: A write to offset 2 with bank 10 loads the scan end channel from bits 5:3 and the scan start channel from bits 2:0. Bits 7:6 are discarded.
- R5: A write to offset 2 with bank 11 changes nothing, and a write to any offset other than 2 and 3 changes nothing.
- R6: In a write to offset 3 with bit 7 = 0, the range code is loaded from bits 3:0 and the bank field is kept. With bit 7 = 1, the bank field is loaded from bits 6:5 and the range code is kept. Bit 4 loads the FIFO half-full interrupt enable on every write to offset 3.
- R7: A read of offset 2 returns {busy flag, digital inputs[2:0], interrupt flag, multiplexer address[2:0]}, MSB first.
- R8: A read of offset 3 returns {scan enable, multiplexer address[2:0], FIFO overflow, range code[2:0]}, MSB first.
- R9: A read of offset 7 with bank 00, 01 or 10 returns {hardware-convert enable, gate enable, interrupt enable, interrupt source, trigger-seen input, trigger enable, cascade enable, timebase enable}, MSB first.
- R10: A read of offset 7 with bank 11 returns the identification byte. Its bits 1:0 are always 11, and bits 7:2 come from parameter `ID_HI` (default 0, giving 8'h03).
- R11: A read of offsets 0, 1, 4, 5 or 6 returns 8'h00, and `rdData` is 8'h00 whenever `rdEn` is low.
- R12: A read and a write in the same cycle return the contents held before the write. The written value is visible from the cycle after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle |
| rdEn | input | 1 | Read strobe, one cycle |
| addr | input | 4 | Byte offset |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte, combinational |
| eocBusy | input | 1 | Converter busy flag |
| digIn | input | 3 | Digital input lines |
| irqFlag | input | 1 | Pending interrupt flag |
| fifoOvf | input | 1 | FIFO overflow flag |
| trigSeen | input | 1 | External trigger has occurred |
| digOut | output | 4 | Digital output lines |
| intEnable | output | 1 | Interrupt enable |
| muxAddr | output | 3 | Input multiplexer address |
| hwConvEn | output | 1 | Hardware conversion master enable |
| gateEn | output | 1 | Gate mode enable |
| scanEn | output | 1 | Automatic channel scan enable |
| srcIsEoc | output | 1 | Interrupt source is end of conversion |
| extTrigEn | output | 1 | External trigger enable |
| cascadeEn | output | 1 | Cascaded pacing enable |
| timebaseEn | output | 1 | Internal timebase enable |
| scanStart | output | 3 | First channel of the scan |
| scanEnd | output | 3 | Last channel of the scan |
| rangeCode | output | 4 | Input range code |
| bankSel | output | 2 | Bank field |
| halfFullIrqEn | output | 1 | FIFO half-full interrupt enable |

## Verification
A host read and a host write can fall in the same cycle. The notable case is a read of offset 2 or 3 while a write to the same offset changes the multiplexer address or the range code. The bench raises both strobes together. It samples `rdData` before the clock edge, where it must still show the old field, and again after the edge, where it must show the new one. The other source of overlap is a write to offset 3 that moves the bank field. The very next write to offset 2 must follow the new bank, and the full sweep of all bytes under all four banks judges this against a model of the stored fields.

// File: rtl/acqRegPkg.sv
package acqRegPkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int DOUT_W = 4;
  localparam int MUX_W = 3;
  localparam int RANGE_W = 4;
  localparam int SCAN_W = 3;
  localparam int BANK_W = 2;
  localparam int ID_HI_W = DATA_W - BANK_W;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_RANGE = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_STAT2 = ADDR_W'(7);

  typedef enum logic [BANK_W-1:0] {
    BANK_CTRL1 = 2'b00,
    BANK_CONV  = 2'b01,
    BANK_SCAN  = 2'b10,
    BANK_ID    = 2'b11
  } bankT;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT1,
    RD_RANGE,
    RD_STAT2,
    RD_ID
  } rdSrcT;

  typedef struct packed {
    logic wrCtrl1;
    logic wrConv;
    logic wrScan;
    logic wrRange;
    logic wrBank;
    logic wrHalf;
  } strobeT;
endpackage

// File: rtl/acqRegCtrl.sv
module acqRegCtrl
  import acqRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit7,
  input  bankT              bankSel,
  output strobeT            strb,
  output rdSrcT             rdSrc
);

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (addr)
        OFS_CTRL: begin
          unique case (bankSel)
            BANK_CTRL1: strb.wrCtrl1 = 1'b1;
            BANK_CONV:  strb.wrConv  = 1'b1;
            BANK_SCAN:  strb.wrScan  = 1'b1;
            default:    ;
          endcase
        end
        OFS_RANGE: begin
          strb.wrHalf = 1'b1;
          if (wrBit7) strb.wrBank = 1'b1;
          else        strb.wrRange = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdSrc = RD_NONE;
    if (rdEn) begin
      unique case (addr)
        OFS_CTRL:  rdSrc = RD_STAT1;
        OFS_RANGE: rdSrc = RD_RANGE;
        OFS_STAT2: rdSrc = (bankSel == BANK_ID) ? RD_ID : RD_STAT2;
        default:   rdSrc = RD_NONE;
      endcase
    end
  end

  // At most one register target per write cycle (R2, R3, R4, R6)
  p_steer_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl1, strb.wrConv, strb.wrScan, strb.wrRange, strb.wrBank}));

  // No strobe reaches a register for offsets other than 2 and 3 (R5)
  p_foreign_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (addr != OFS_CTRL && addr != OFS_RANGE) |-> (strb == '0));

endmodule

// File: rtl/acqRegData.sv
module acqRegData
  import acqRegPkg::*;
#(
  parameter logic [ID_HI_W-1:0] ID_HI = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  rdSrcT              rdSrc,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               eocBusy,
  input  logic [2:0]         digIn,
  input  logic               irqFlag,
  input  logic               fifoOvf,
  input  logic               trigSeen,
  output logic [DATA_W-1:0]  rdData,
  output logic [DOUT_W-1:0]  digOut,
  output logic               intEnable,
  output logic [MUX_W-1:0]   muxAddr,
  output logic               hwConvEn,
  output logic               gateEn,
  output logic               scanEn,
  output logic               srcIsEoc,
  output logic               extTrigEn,
  output logic               cascadeEn,
  output logic               timebaseEn,
  output logic [SCAN_W-1:0]  scanStart,
  output logic [SCAN_W-1:0]  scanEnd,
  output logic [RANGE_W-1:0] rangeCode,
  output bankT               bankSel,
  output logic               halfFullIrqEn
);

  localparam logic [DATA_W-1:0] ID_BYTE = {ID_HI, 2'b11};

  // control register 1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      digOut    <= '0;
      intEnable <= 1'b0;
      muxAddr   <= '0;
    end else if (strb.wrCtrl1) begin
      digOut    <= wrData[7:4];
      intEnable <= wrData[3];
      muxAddr   <= wrData[2:0];
    end
  end

  // conversion control
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hwConvEn   <= 1'b0;
      gateEn     <= 1'b0;
      scanEn     <= 1'b0;
      srcIsEoc   <= 1'b0;
      extTrigEn  <= 1'b0;
      cascadeEn  <= 1'b0;
      timebaseEn <= 1'b0;
    end else if (strb.wrConv) begin
      hwConvEn   <= wrData[7];
      gateEn     <= wrData[5];
      scanEn     <= wrData[4];
      srcIsEoc   <= wrData[3];
      extTrigEn  <= wrData[2];
      cascadeEn  <= wrData[1];
      timebaseEn <= wrData[0];
    end
  end

  // scan limits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanEnd   <= '0;
      scanStart <= '0;
    end else if (strb.wrScan) begin
      scanEnd   <= wrData[5:3];
      scanStart <= wrData[2:0];
    end
  end

  // range / bank byte: bit 7 gates which field may move
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rangeCode     <= '0;
      bankSel       <= BANK_CTRL1;
      halfFullIrqEn <= 1'b0;
    end else begin
      if (strb.wrRange) rangeCode <= wrData[3:0];
      if (strb.wrBank)  bankSel   <= bankT'(wrData[6:5]);
      if (strb.wrHalf)  halfFullIrqEn <= wrData[4];
    end
  end

  always_comb begin
    unique case (rdSrc)
      RD_STAT1: rdData = {eocBusy, digIn, irqFlag, muxAddr};
      RD_RANGE: rdData = {scanEn, muxAddr, fifoOvf, rangeCode[2:0]};
      RD_STAT2: rdData = {hwConvEn, gateEn, intEnable, srcIsEoc,
                          trigSeen, extTrigEn, cascadeEn, timebaseEn};
      RD_ID:    rdData = ID_BYTE;
      default:  rdData = '0;
    endcase
  end

  // Range code is frozen by a bank-selecting write (R6)
  p_range_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBank |=> $stable(rangeCode));

  // Bank field is frozen by a range-writing write (R6)
  p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrRange |=> $stable(bankSel));

  // Control register 1 takes the written nibble (R2)
  p_ctrl1_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl1 |=> (digOut == $past(wrData[7:4])));

  // Scan limits untouched unless their strobe fires (R5)
  p_scan_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrScan |=> ($stable(scanEnd) && $stable(scanStart)));

endmodule

// File: rtl/acqHostRegs.sv
module acqHostRegs
  import acqRegPkg::*;
#(
  parameter logic [ID_HI_W-1:0] ID_HI = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic               eocBusy,
  input  logic [2:0]         digIn,
  input  logic               irqFlag,
  input  logic               fifoOvf,
  input  logic               trigSeen,
  output logic [DOUT_W-1:0]  digOut,
  output logic               intEnable,
  output logic [MUX_W-1:0]   muxAddr,
  output logic               hwConvEn,
  output logic               gateEn,
  output logic               scanEn,
  output logic               srcIsEoc,
  output logic               extTrigEn,
  output logic               cascadeEn,
  output logic               timebaseEn,
  output logic [SCAN_W-1:0]  scanStart,
  output logic [SCAN_W-1:0]  scanEnd,
  output logic [RANGE_W-1:0] rangeCode,
  output logic [BANK_W-1:0]  bankSel,
  output logic               halfFullIrqEn
);

  strobeT strb;
  rdSrcT  rdSrc;
  bankT   bankQ;

  assign bankSel = bankQ;

  acqRegCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .wrBit7  (wrData[7]),
    .bankSel (bankQ),
    .strb    (strb),
    .rdSrc   (rdSrc)
  );

  acqRegData #(.ID_HI(ID_HI)) uData (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .rdSrc         (rdSrc),
    .wrData        (wrData),
    .eocBusy       (eocBusy),
    .digIn         (digIn),
    .irqFlag       (irqFlag),
    .fifoOvf       (fifoOvf),
    .trigSeen      (trigSeen),
    .rdData        (rdData),
    .digOut        (digOut),
    .intEnable     (intEnable),
    .muxAddr       (muxAddr),
    .hwConvEn      (hwConvEn),
    .gateEn        (gateEn),
    .scanEn        (scanEn),
    .srcIsEoc      (srcIsEoc),
    .extTrigEn     (extTrigEn),
    .cascadeEn     (cascadeEn),
    .timebaseEn    (timebaseEn),
    .scanStart     (scanStart),
    .scanEnd       (scanEnd),
    .rangeCode     (rangeCode),
    .bankSel       (bankQ),
    .halfFullIrqEn (halfFullIrqEn)
  );

  // Identification byte always ends in 11 (R10)
  p_id_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == OFS_STAT2 && bankSel == 2'b11) |-> (rdData[1:0] == 2'b11));

  // Bus is quiet without a read strobe (R11)
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == '0));

endmodule

// File: tb/acqHostRegs_test.sv
module acqHostRegs_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic eocBusy = 1'b0, irqFlag = 1'b0, fifoOvf = 1'b0, trigSeen = 1'b0;
  logic [2:0] digIn = '0;
  logic [3:0] digOut;
  logic intEnable, hwConvEn, gateEn, scanEn, srcIsEoc, extTrigEn, cascadeEn, timebaseEn;
  logic halfFullIrqEn;
  logic [2:0] muxAddr, scanStart, scanEnd;
  logic [3:0] rangeCode;
  logic [1:0] bankSel;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // model of stored fields
  logic [7:0] mCtrl1 = '0;
  logic [7:0] mConv = '0;
  logic [5:0] mScan = '0;
  logic [3:0] mRange = '0;
  logic [1:0] mBank = '0;
  logic       mHalf = 1'b0;

  always #4 clk = ~clk;

  acqHostRegs uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .eocBusy(eocBusy), .digIn(digIn),
    .irqFlag(irqFlag), .fifoOvf(fifoOvf), .trigSeen(trigSeen),
    .digOut(digOut), .intEnable(intEnable), .muxAddr(muxAddr),
    .hwConvEn(hwConvEn), .gateEn(gateEn), .scanEn(scanEn),
    .srcIsEoc(srcIsEoc), .extTrigEn(extTrigEn), .cascadeEn(cascadeEn),
    .timebaseEn(timebaseEn), .scanStart(scanStart), .scanEnd(scanEnd),
    .rangeCode(rangeCode), .bankSel(bankSel), .halfFullIrqEn(halfFullIrqEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] actState();
    return {3'b0, digOut, intEnable, muxAddr,
            hwConvEn, 1'b0, gateEn, scanEn, srcIsEoc, extTrigEn, cascadeEn, timebaseEn,
            scanEnd, scanStart, rangeCode, bankSel, halfFullIrqEn};
  endfunction

  function automatic logic [31:0] expState();
    return {3'b0, mCtrl1, mConv, mScan, mRange, mBank, mHalf};
  endfunction

  function automatic void modelWrite(input logic [3:0] a, input logic [7:0] d);
    if (a == 4'd2) begin
      case (mBank)
        2'b00: mCtrl1 = d;
        2'b01: mConv = d & 8'hBF;
        2'b10: mScan = d[5:0];
        default: ;
      endcase
    end else if (a == 4'd3) begin
      mHalf = d[4];
      if (d[7]) mBank = d[6:5];
      else      mRange = d[3:0];
    end
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic logic [7:0] expStat1();
    return {eocBusy, digIn, irqFlag, mCtrl1[2:0]};
  endfunction
  function automatic logic [7:0] expRng();
    return {mConv[4], mCtrl1[2:0], fifoOvf, mRange[2:0]};
  endfunction
  function automatic logic [7:0] expStat2();
    return {mConv[7], mConv[5], mCtrl1[3], mConv[3], trigSeen, mConv[2:0]};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset state", actState(), 32'h0);

    // R2..R5: every byte to offset 2 under every bank
    for (int b = 0; b < 4; b++) begin
      wr(4'd3, {1'b1, 2'(b), 5'b0});
      chk("R6 bank set", {30'b0, bankSel}, {30'b0, 2'(b)});
      for (int d = 0; d < 256; d++) begin
        wr(4'd2, 8'(d));
        case (b)
          0: chk("R2 ctrl1 write", actState(), expState());
          1: chk("R3 conv write", actState(), expState());
          2: chk("R4 scan write", actState(), expState());
          default: chk("R5 bank 11 write ignored", actState(), expState());
        endcase
      end
    end

    // R6: every byte to offset 3
    for (int d = 0; d < 256; d++) begin
      wr(4'd3, 8'(d));
      chk("R6 range/bank write", actState(), expState());
    end

    // R5: foreign offsets ignored
    wr(4'd3, 8'h80);
    for (int a = 0; a < 16; a++) begin
      if (a != 2 && a != 3) begin
        wr(4'(a), 8'hFF);
        chk("R5 foreign write ignored", actState(), expState());
      end
    end

    // R7/R8/R9: reads over status input patterns and stored contents
    for (int k = 0; k < 4; k++) begin
      wr(4'd3, 8'h80);
      wr(4'd2, 8'h5A ^ 8'(k * 37));
      wr(4'd3, 8'hA0);
      wr(4'd2, 8'hC3 ^ 8'(k * 91));
      wr(4'd3, 8'h80);
      wr(4'd3, 8'(k * 5));
      for (int s = 0; s < 128; s++) begin
        {eocBusy, digIn, irqFlag, fifoOvf, trigSeen} = 7'(s);
        rd(4'd2, v); chk("R7 status1 read", {24'b0, v}, {24'b0, expStat1()});
        rd(4'd3, v); chk("R8 range read", {24'b0, v}, {24'b0, expRng()});
        rd(4'd7, v); chk("R9 status2 read", {24'b0, v}, {24'b0, expStat2()});
      end
    end

    // R9 with bank 01 and 10, R10 with bank 11
    wr(4'd3, 8'hA0);
    rd(4'd7, v); chk("R9 status2 bank 01", {24'b0, v}, {24'b0, expStat2()});
    wr(4'd3, 8'hC0);
    rd(4'd7, v); chk("R9 status2 bank 10", {24'b0, v}, {24'b0, expStat2()});
    wr(4'd3, 8'hE0);
    rd(4'd7, v); chk("R10 id byte", {24'b0, v}, 32'h03);

    // R11: other offsets and idle bus
    for (int a = 0; a < 16; a++) begin
      if (a != 2 && a != 3 && a != 7) begin
        rd(4'(a), v); chk("R11 unused offset read", {24'b0, v}, 32'h0);
      end
    end
    @(negedge clk);
    addr = 4'd2; rdEn = 1'b0;
    #1 chk("R11 idle bus", {24'b0, rdData}, 32'h0);

    // R12: read and write together on offset 2, then on offset 3
    wr(4'd3, 8'h80);
    wr(4'd2, 8'h01);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 4'd2; wrData = 8'h06;
    #1 chk("R12 same-cycle read old", {29'b0, rdData[2:0]}, 32'h1);
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(4'd2, 8'h06);
    #1 chk("R12 new value next cycle", {29'b0, rdData[2:0]}, 32'h6);
    @(negedge clk);
    rdEn = 1'b0;
    wr(4'd3, 8'h05);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 4'd3; wrData = 8'h02;
    #1 chk("R12 same-cycle range old", {29'b0, rdData[2:0]}, 32'h5);
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(4'd3, 8'h02);
    #1 chk("R12 range new next cycle", {29'b0, rdData[2:0]}, 32'h2);
    @(negedge clk);
    rdEn = 1'b0;

    // R1: reset again clears everything
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mCtrl1 = '0; mConv = '0; mScan = '0; mRange = '0; mBank = '0; mHalf = 1'b0;
    @(negedge clk);
    chk("R1 reset after use", actState(), 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule